// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block is the instruction-address sequencer of a small 8-bit controller core. It holds a 12-bit program counter that addresses a 4096-word instruction memory organised as four pages of 1024 words, and an 8-entry hardware return stack for subroutine nesting. The decode stage hands it one-cycle strobes: advance to the next word, absolute jump, subroutine call, subroutine return, and three forms of writing the counter as if it were a data register (add an 8-bit value to its low byte, move an 8-bit value into its low byte, clear one bit of its low byte). With the strobes come a 10-bit immediate, an 8-bit data value, a bit index and the two page-select bits from the status register. The block drives the fetch address and a stall request.

Jumps, calls and register-form writes take the page from the page-select input. A return takes the whole 12-bit address from the stack, so it lands on the caller's page whatever the page-select input holds. Register-form writes force bits 9:8 to zero, so a computed jump stays within the first 256 words of the selected page. Every redirect costs one extra cycle. A two-state machine handles it. In state RUN it accepts strobes. Any redirect (jump, call, return or register-form write) moves it to REFILL. In REFILL it raises the stall request, holds the counter and ignores all strobes, and it returns to RUN on the next clock. With no redirect it stays in RUN.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is low and in the first cycle after it, fetch_addr_o is 0x000 and stall_o is 0. Reset also clears every stack entry to 0x000.
- R2: In RUN, a step strobe with no other strobe sets fetch_addr_o to the old value plus one, and 0xFFF wraps to 0x000. With no strobe at all the address holds.
- R3: A jump loads bits 9:0 from imm_i and bits 11:10 from page_sel_i (page_sel_i bit 1 goes to address bit 11).
- R4: A call loads the same target as a jump and pushes the old address plus one (modulo 4096) onto the stack.
- R5: A return loads all 12 address bits from the top of the stack and pops it. page_sel_i and imm_i have no effect on a return.
- R6: An add write gives {page_sel_i, 2'b00, (old bits 7:0 + data_i) mod 256}.
- R7: A move write gives {page_sel_i, 2'b00, data_i}.
- R8: A bit-clear write gives {page_sel_i, 2'b00, old bits 7:0 with bit bit_sel_i forced to 0}.
- R9: After any redirect, stall_o is 1 for exactly the next cycle. In that cycle the address holds and every strobe is ignored, including stack operations.
- R10: When several strobes arrive together, only one acts. The order, from highest to lowest, is return, call, jump, add, move, bit-clear, step.
- R11: The stack is last-in first-out with 8 levels and a circular pointer. A ninth push overwrites the oldest entry. A pop with no valid entries returns the entry under the wrapped pointer, and no error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Advance to the next word |
| jump_i | input | 1 | Absolute jump within the selected page |
| call_i | input | 1 | Subroutine call; pushes the return address |
| ret_i | input | 1 | Return from subroutine; pops the stack |
| add_i | input | 1 | Register write: add data_i to the low byte |
| mov_i | input | 1 | Register write: load data_i into the low byte |
| bclr_i | input | 1 | Register write: clear bit bit_sel_i of the low byte |
| imm_i | input | 10 | Page-offset target for jump and call |
| data_i | input | 8 | Operand for add and move writes |
| bit_sel_i | input | 3 | Bit index for the bit-clear write |
| page_sel_i | input | 2 | Page-select bits from the status register |
| fetch_addr_o | output | 12 | Current instruction fetch address |
| stall_o | output | 1 | One-cycle refill request after a redirect |

## Verification
The hardest cases to reach from the ports are stack wrap-around and the pop from an empty stack. The bench gets there by nesting calls ten deep, each from a different page and offset, so the pointer passes the eighth level and overwrites the oldest return addresses. It then unwinds eleven times, which drains the valid entries and then pops through the wrapped pointer. To show that strobes in the refill cycle are ignored, the bench drives return, call and jump together in every refill cycle. A missed guard would then corrupt both the address and the later unwind. A model of the stack in the bench predicts every returned address.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

    typedef enum logic [0:0] {
        ST_RUN    = 1'b0,
        ST_REFILL = 1'b1
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_STEP = 3'd1,
        OP_JUMP = 3'd2,
        OP_CALL = 3'd3,
        OP_RET  = 3'd4,
        OP_ADD  = 3'd5,
        OP_MOV  = 3'd6,
        OP_BCLR = 3'd7
    } pc_op_e;

endpackage

// File: rtl/pc_ctrl.sv
module pc_ctrl
    import pc_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   step_i,
    input  logic   jump_i,
    input  logic   call_i,
    input  logic   ret_i,
    input  logic   add_i,
    input  logic   mov_i,
    input  logic   bclr_i,
    output pc_op_e op_o,
    output logic   stall_o
);

    seq_state_e state_q, state_d;
    pc_op_e     pick;

    // Fixed priority among the strobes (R10)
    always_comb begin
        if (ret_i)       pick = OP_RET;
        else if (call_i) pick = OP_CALL;
        else if (jump_i) pick = OP_JUMP;
        else if (add_i)  pick = OP_ADD;
        else if (mov_i)  pick = OP_MOV;
        else if (bclr_i) pick = OP_BCLR;
        else if (step_i) pick = OP_STEP;
        else             pick = OP_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        op_o    = OP_NONE;
        stall_o = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                op_o = pick;
                if (pick != OP_NONE && pick != OP_STEP) state_d = ST_REFILL;
            end
            ST_REFILL: begin
                stall_o = 1'b1;
                state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

endmodule

// File: rtl/pc_next.sv
module pc_next
    import pc_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OFF_W  = 10,
    parameter int LOW_W  = 8,
    localparam int PAGE_W = ADDR_W - OFF_W,
    localparam int GAP_W  = OFF_W - LOW_W,
    localparam int BIT_W  = $clog2(LOW_W)
) (
    input  pc_op_e            op_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [OFF_W-1:0]  imm_i,
    input  logic [LOW_W-1:0]  data_i,
    input  logic [BIT_W-1:0]  bit_sel_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [ADDR_W-1:0] top_i,
    output logic [ADDR_W-1:0] nxt_o,
    output logic              push_o,
    output logic              pop_o,
    output logic [ADDR_W-1:0] ret_addr_o
);

    localparam logic [ADDR_W-1:0] INC = ADDR_W'(1);

    logic [LOW_W-1:0] low_sum;
    logic [LOW_W-1:0] low_clr;

    assign ret_addr_o = pc_i + INC;
    assign low_sum    = pc_i[LOW_W-1:0] + data_i;

    always_comb begin
        low_clr            = pc_i[LOW_W-1:0];
        low_clr[bit_sel_i] = 1'b0;
    end

    always_comb begin
        nxt_o  = pc_i;
        push_o = 1'b0;
        pop_o  = 1'b0;
        unique case (op_i)
            OP_NONE: nxt_o = pc_i;
            OP_STEP: nxt_o = ret_addr_o;
            OP_JUMP: nxt_o = {page_i, imm_i};
            OP_CALL: begin
                nxt_o  = {page_i, imm_i};
                push_o = 1'b1;
            end
            OP_RET: begin
                nxt_o = top_i;
                pop_o = 1'b1;
            end
            OP_ADD:  nxt_o = {page_i, {GAP_W{1'b0}}, low_sum};
            OP_MOV:  nxt_o = {page_i, {GAP_W{1'b0}}, data_i};
            OP_BCLR: nxt_o = {page_i, {GAP_W{1'b0}}, low_clr};
            default: nxt_o = pc_i;
        endcase
    end

endmodule

// File: rtl/pc_stack.sv
module pc_stack #(
    parameter int W     = 12,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] top_o
);

    localparam logic [PTR_W-1:0] STEP1 = PTR_W'(1);

    logic [PTR_W-1:0] sp_q;
    logic [W-1:0]     slots [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sp_q <= '0;
        else if (push_i) sp_q <= sp_q + STEP1;
        else if (pop_i)  sp_q <= sp_q - STEP1;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [W-1:0] ent_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             ent_q <= '0;
            else if (push_i && sp_q == PTR_W'(i))   ent_q <= din_i;
        end
        assign slots[i] = ent_q;
    end

    assign top_o = slots[sp_q - STEP1];

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pc_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OFF_W  = 10,
    parameter int LOW_W  = 8,
    parameter int DEPTH  = 8,
    localparam int PAGE_W = ADDR_W - OFF_W,
    localparam int BIT_W  = $clog2(LOW_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              jump_i,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic              add_i,
    input  logic              mov_i,
    input  logic              bclr_i,
    input  logic [OFF_W-1:0]  imm_i,
    input  logic [LOW_W-1:0]  data_i,
    input  logic [BIT_W-1:0]  bit_sel_i,
    input  logic [PAGE_W-1:0] page_sel_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic              stall_o
);

    pc_op_e            op;
    logic [ADDR_W-1:0] pc_q, pc_d, top, ret_addr;
    logic              push, pop;

    pc_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step_i),
        .jump_i  (jump_i),
        .call_i  (call_i),
        .ret_i   (ret_i),
        .add_i   (add_i),
        .mov_i   (mov_i),
        .bclr_i  (bclr_i),
        .op_o    (op),
        .stall_o (stall_o)
    );

    pc_next #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LOW_W(LOW_W)) u_next (
        .op_i       (op),
        .pc_i       (pc_q),
        .imm_i      (imm_i),
        .data_i     (data_i),
        .bit_sel_i  (bit_sel_i),
        .page_i     (page_sel_i),
        .top_i      (top),
        .nxt_o      (pc_d),
        .push_o     (push),
        .pop_o      (pop),
        .ret_addr_o (ret_addr)
    );

    pc_stack #(.W(ADDR_W), .DEPTH(DEPTH)) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (push),
        .pop_i  (pop),
        .din_i  (ret_addr),
        .top_o  (top)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign fetch_addr_o = pc_q;

endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
    parameter int ADDR_W = 12,
    parameter int OFF_W  = 10,
    parameter int LOW_W  = 8,
    localparam int PAGE_W = ADDR_W - OFF_W,
    localparam int BIT_W  = $clog2(LOW_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_i,
    input logic              jump_i,
    input logic              call_i,
    input logic              ret_i,
    input logic              add_i,
    input logic              mov_i,
    input logic              bclr_i,
    input logic [OFF_W-1:0]  imm_i,
    input logic [LOW_W-1:0]  data_i,
    input logic [BIT_W-1:0]  bit_sel_i,
    input logic [PAGE_W-1:0] page_sel_i,
    input logic [ADDR_W-1:0] fetch_addr_o,
    input logic              stall_o
);

    logic flow_op, reg_op;
    assign flow_op = jump_i | call_i | ret_i;
    assign reg_op  = add_i | mov_i | bclr_i;

    assert_refill_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> !stall_o);

    assert_refill_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> $stable(fetch_addr_o));

    assert_jump_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && jump_i && !call_i && !ret_i)
        |=> stall_o && fetch_addr_o == {$past(page_sel_i), $past(imm_i)});

    assert_step_incr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && step_i && !flow_op && !reg_op)
        |=> !stall_o && fetch_addr_o == ADDR_W'($past(fetch_addr_o) + 1'b1));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && !step_i && !flow_op && !reg_op) |=> $stable(fetch_addr_o));

    // covers R6, R7 and R8: register-form writes keep page and clear bits 9:8
    assert_regwr_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && !flow_op && reg_op)
        |=> stall_o && fetch_addr_o[OFF_W-1:LOW_W] == '0
            && fetch_addr_o[ADDR_W-1:OFF_W] == $past(page_sel_i));

    assert_move_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && !flow_op && !add_i && mov_i)
        |=> fetch_addr_o[LOW_W-1:0] == $past(data_i));

endmodule

bind pc_sequencer pc_sequencer_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .LOW_W  (LOW_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_i       (step_i),
    .jump_i       (jump_i),
    .call_i       (call_i),
    .ret_i        (ret_i),
    .add_i        (add_i),
    .mov_i        (mov_i),
    .bclr_i       (bclr_i),
    .imm_i        (imm_i),
    .data_i       (data_i),
    .bit_sel_i    (bit_sel_i),
    .page_sel_i   (page_sel_i),
    .fetch_addr_o (fetch_addr_o),
    .stall_o      (stall_o)
);

// File: tb/pc_sequencer_tb_top.sv
module pc_sequencer_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 0, jump_i = 0, call_i = 0, ret_i = 0;
    logic        add_i = 0, mov_i = 0, bclr_i = 0;
    logic [9:0]  imm_i = '0;
    logic [7:0]  data_i = '0;
    logic [2:0]  bit_sel_i = '0;
    logic [1:0]  page_sel_i = '0;
    logic [11:0] fetch_addr_o;
    logic        stall_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [11:0] exp_pc;
    logic [11:0] exp_stk [8];
    int          exp_sp;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .jump_i(jump_i),
        .call_i(call_i), .ret_i(ret_i), .add_i(add_i), .mov_i(mov_i),
        .bclr_i(bclr_i), .imm_i(imm_i), .data_i(data_i), .bit_sel_i(bit_sel_i),
        .page_sel_i(page_sel_i), .fetch_addr_o(fetch_addr_o), .stall_o(stall_o)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        {step_i, jump_i, call_i, ret_i, add_i, mov_i, bclr_i} = '0;
    endtask

    // Applies strobes at a falling edge and predicts the result from the requirements.
    // s = {ret, call, jump, add, mov, bclr, step}
    task automatic apply(input logic [6:0] s, input logic [1:0] pg, input logic [9:0] imm,
                         input logic [7:0] dat, input logic [2:0] bs, input string req);
        logic        redirect;
        logic [7:0]  low;
        {ret_i, call_i, jump_i, add_i, mov_i, bclr_i, step_i} = s;
        page_sel_i = pg; imm_i = imm; data_i = dat; bit_sel_i = bs;
        redirect = 1'b1;
        if (s[6]) begin
            exp_sp = (exp_sp + 7) % 8;
            exp_pc = exp_stk[exp_sp];
        end else if (s[5]) begin
            exp_stk[exp_sp] = exp_pc + 12'd1;
            exp_sp = (exp_sp + 1) % 8;
            exp_pc = {pg, imm};
        end else if (s[4]) begin
            exp_pc = {pg, imm};
        end else if (s[3]) begin
            low = exp_pc[7:0] + dat;
            exp_pc = {pg, 2'b00, low};
        end else if (s[2]) begin
            exp_pc = {pg, 2'b00, dat};
        end else if (s[1]) begin
            low = exp_pc[7:0];
            low[bs] = 1'b0;
            exp_pc = {pg, 2'b00, low};
        end else begin
            redirect = 1'b0;
            if (s[0]) exp_pc = exp_pc + 12'd1;
        end
        @(negedge clk);
        check(req, fetch_addr_o, exp_pc);
        check({req, " R9 stall"}, {11'd0, stall_o}, {11'd0, redirect});
        if (redirect) begin
            // strobes in the refill cycle must be ignored (R9)
            {ret_i, call_i, jump_i, add_i, mov_i, bclr_i, step_i} = 7'h7F;
            page_sel_i = ~pg; imm_i = ~imm; data_i = ~dat;
            @(negedge clk);
            check("R9 hold", fetch_addr_o, exp_pc);
            check("R9 release", {11'd0, stall_o}, 12'd0);
        end
        clear_in();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_pc = '0;
        exp_sp = 0;
        for (int i = 0; i < 8; i++) exp_stk[i] = '0;
        repeat (3) @(negedge clk);
        check("R1 reset addr", fetch_addr_o, 12'h000);
        check("R1 reset stall", {11'd0, stall_o}, 12'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", fetch_addr_o, 12'h000);

        // empty pop after reset returns a cleared entry (R1, R11)
        apply(7'b1000000, 2'd3, 10'h155, 8'h00, 3'd0, "R11 empty pop");

        // R2: step and idle
        for (int k = 0; k < 5; k++) apply(7'b0000001, 2'd0, 10'h0, 8'h0, 3'd0, "R2 step");
        apply(7'b0000000, 2'd0, 10'h0, 8'h0, 3'd0, "R2 idle");

        // R3: jump sweep over pages and offsets
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 8; k++) begin
                logic [9:0] t;
                t = 10'((k * 147 + p * 61) % 1024);
                if (k == 0) t = 10'h000;
                if (k == 7) t = 10'h3FF;
                apply(7'b0010000, 2'(p), t, 8'h0, 3'd0, "R3 jump");
            end
        end

        // R2: wrap from the top of memory
        apply(7'b0010000, 2'd3, 10'h3FE, 8'h0, 3'd0, "R3 jump");
        apply(7'b0000001, 2'd0, 10'h0, 8'h0, 3'd0, "R2 step");
        apply(7'b0000001, 2'd0, 10'h0, 8'h0, 3'd0, "R2 wrap");

        // R6: add sweep over every data value
        for (int d = 0; d < 256; d++) begin
            apply(7'b0010000, 2'(d % 4), 10'(10'h2C0 + d), 8'h0, 3'd0, "R3 jump");
            apply(7'b0001000, 2'((d + 1) % 4), 10'h0, 8'(d), 3'd0, "R6 add");
        end

        // R7: move sweep
        for (int d = 0; d < 256; d += 3) begin
            apply(7'b0010000, 2'd1, 10'h3FF, 8'h0, 3'd0, "R3 jump");
            apply(7'b0000100, 2'(d % 4), 10'h0, 8'(d), 3'd0, "R7 move");
        end

        // R8: bit-clear sweep over every index and page
        for (int p = 0; p < 4; p++) begin
            for (int b = 0; b < 8; b++) begin
                apply(7'b0010000, 2'(3 - p), 10'h3FF, 8'h0, 3'd0, "R3 jump");
                apply(7'b0000010, 2'(p), 10'h0, 8'h0, 3'(b), "R8 bit clear");
            end
        end

        // R4, R5, R11: ten nested calls, then eleven returns
        apply(7'b0010000, 2'd2, 10'h1A0, 8'h0, 3'd0, "R3 jump");
        for (int n = 0; n < 10; n++) begin
            apply(7'b0000001, 2'd0, 10'h0, 8'h0, 3'd0, "R2 step");
            apply(7'b0100000, 2'(n % 4), 10'(n * 91 + 5), 8'h0, 3'd0, "R4 call");
        end
        for (int n = 0; n < 11; n++) begin
            apply(7'b1000000, 2'(n % 4), 10'h3FF, 8'h0, 3'd0, "R5 R11 return");
        end

        // R10: priority among simultaneous strobes
        apply(7'b0100000, 2'd1, 10'h111, 8'h0, 3'd0, "R4 call");
        apply(7'b1111111, 2'd2, 10'h222, 8'h33, 3'd4, "R10 return wins");
        apply(7'b0111111, 2'd3, 10'h0F0, 8'h44, 3'd4, "R10 call wins");
        apply(7'b0011111, 2'd0, 10'h2AB, 8'h55, 3'd4, "R10 jump wins");
        apply(7'b0001111, 2'd1, 10'h0, 8'h0F, 3'd4, "R10 add wins");
        apply(7'b0000111, 2'd2, 10'h0, 8'hF7, 3'd4, "R10 move wins");
        apply(7'b0000011, 2'd3, 10'h0, 8'h00, 3'd1, "R10 bit clear wins");
        apply(7'b1000000, 2'd0, 10'h0, 8'h0, 3'd0, "R10 R5 return");
        apply(7'b1000000, 2'd0, 10'h0, 8'h0, 3'd0, "R11 drained pop");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule